// File: doc/BRIEF.md
# Reference-Based Frequency Lock Detector

This block decides whether a recovered clock runs at the frequency it should, judged against a trusted reference clock. A free-running monitor clock samples both clocks through synchronizers and detects their rising edges. Over a measurement window of a fixed number of reference edges, the block counts recovered-clock edges and compares the total against the expected count. The allowed deviation is picked by a 2-bit select input. When the recovered frequency is in range, the `lock` output goes high. When it is out of range, `lock` drops for one window and is then tried again. A recovered clock that stays off frequency therefore makes `lock` toggle with a period of two windows.

A separate watch on the reference clock pulls `lock` low when no reference edge arrives within a set number of monitor cycles. The active-low reset forces `lock` low at once and restarts the measurement. Control is a four-state machine:

- ACQUIRE: first measurement, `lock` low.
- LOCKED: `lock` high, still measuring.
- HOLDOFF: one window with `lock` low, whose result is ignored.
- NOREF: reference missing, `lock` low.

Transitions:

- ACQUIRE→LOCKED: in range.
- ACQUIRE→HOLDOFF: out of range.
- LOCKED→HOLDOFF: out of range.
- HOLDOFF→LOCKED: the relock attempt, taken at the end of the window.
- Any of ACQUIRE, LOCKED or HOLDOFF → NOREF: the reference has timed out.
- NOREF→ACQUIRE: a reference edge is seen again.

Top module: `freq_lock_detector`

## Requirements
- R1: While `rst_n` is low, `lock` is 0 at once (asynchronously), the state is ACQUIRE and all counts are zero. After release, the first window starts from empty counts.
- R2: Each of `ref_clk_in` and `rec_clk_in` is sampled by `clk` through a two-stage synchronizer. An edge counts when the synchronized value is 1 after being 0. A steady input, high or low, contributes no edges.
- R3: A window closes on the 2**WIN_LOG2-th detected reference edge (1024 by default). A recovered edge detected in the same cycle belongs to the closing window. Both counts then restart from zero, so `lock` can never rise before a whole window has been measured.
- R4: The expected recovered count is 2**WIN_LOG2 × RATIO. The tolerance is TOL_BASE shifted left by `tol_sel`: 00→±2, 01→±4, 10→±8, 11→±16 with the default TOL_BASE of 2. A window is in range when |count − expected| ≤ tolerance, using the `tol_sel` value present in the closing cycle.
- R5: `lock` is 1 exactly when the state is LOCKED. ACQUIRE moves to LOCKED after an in-range window and to HOLDOFF after an out-of-range window. LOCKED stays in LOCKED while windows are in range.
- R6: An out-of-range window in LOCKED moves to HOLDOFF. HOLDOFF keeps `lock` low for one full window, whatever that window measures, and then moves to LOCKED. A persistent mismatch therefore toggles `lock`, one window high and one window low.
- R7: If MISS_LIMIT monitor cycles pass with no detected reference edge, and the next cycle brings none either, the state becomes NOREF: `lock` goes low and the counts clear. This is 64 cycles by default.
- R8: In NOREF, the first detected reference edge moves the state to ACQUIRE. That edge is not counted, and a complete window is needed before `lock` may rise again.
- R9: `lock` changes only on the clock edge after a state change, and it rises only in a cycle that closed a window on a detected reference edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running monitor clock that samples both measured clocks |
| rst_n | input | 1 | Active-low receiver reset, asynchronous assertion |
| ref_clk_in | input | 1 | Reference clock, treated as a sampled signal |
| rec_clk_in | input | 1 | Recovered clock under test, treated as a sampled signal |
| tol_sel | input | 2 | Tolerance select: 00 ±2, 01 ±4, 10 ±8, 11 ±16 counts per window |
| lock | output | 1 | High while the recovered frequency is judged in specification |

## Verification
The recovered clock is produced by a phase accumulator, so each window carries a chosen offset from the expected count. The offset is applied under each tolerance setting: an offset of 6 is rejected at ±2 and accepted at ±8, an offset of 12 is accepted at ±16, and −10 is rejected at ±4. This separates the four select decodes and the sign handling of the deviation. A recovered input frozen at a steady level shows that only rising transitions count. Stopping and restarting the reference separates the timeout path and the fresh acquisition from an ordinary out-of-range drop. A persistent offset shows the one-window-high, one-window-low toggling, and a behavioural model compared on every clock pins down the exact cycle of every transition.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_HOLDOFF = 2'd2,
        ST_NOREF   = 2'd3
    } lock_state_e;
endpackage

// File: rtl/fld_edge_sync.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous level and emits a one-cycle pulse on its rising edge.
module fld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/fld_ref_watch.sv
`timescale 1ns/1ps
// Counts monitor cycles since the last reference edge; flags a timeout.
module fld_ref_watch #(
    parameter int MISS_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    output logic expired
);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [MW-1:0] LIM = MW'(MISS_LIMIT);

    logic [MW-1:0] miss_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            miss_cnt <= '0;
        else if (ref_rise)     miss_cnt <= '0;
        else if (miss_cnt != LIM) miss_cnt <= miss_cnt + MW'(1);
    end

    assign expired = !ref_rise && (miss_cnt == LIM);
endmodule

// File: rtl/fld_window_meter.sv
`timescale 1ns/1ps
// Counts reference and recovered edges over one window and grades the result.
module fld_window_meter #(
    parameter int WIN_LOG2 = 10,
    parameter int RATIO    = 1,
    parameter int TOL_BASE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       ref_rise,
    input  logic       rec_rise,
    input  logic [1:0] tol_sel,
    output logic       win_done,
    output logic       in_range
);
    localparam int WIN     = 1 << WIN_LOG2;
    localparam int EXP_CNT = WIN * RATIO;
    localparam int REF_W   = WIN_LOG2;
    localparam int REC_W   = $clog2(2 * EXP_CNT + 2);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(WIN - 1);
    localparam logic [REC_W:0]   EXPECT_V = (REC_W+1)'(EXP_CNT);
    localparam logic [REC_W:0]   TOL_V    = (REC_W+1)'(TOL_BASE);

    logic [REF_W-1:0] ref_cnt;
    logic [REC_W-1:0] rec_cnt;
    logic [REC_W:0]   total;
    logic [REC_W:0]   dev;
    logic [REC_W:0]   tol;

    assign win_done = ref_rise && (ref_cnt == REF_LAST);
    assign total    = {1'b0, rec_cnt} + {{REC_W{1'b0}}, rec_rise};
    assign dev      = (total >= EXPECT_V) ? (total - EXPECT_V) : (EXPECT_V - total);
    assign tol      = TOL_V << tol_sel;
    assign in_range = (dev <= tol);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            rec_cnt <= '0;
        end else if (clear || win_done) begin
            ref_cnt <= '0;
            rec_cnt <= '0;
        end else begin
            if (ref_rise)
                ref_cnt <= ref_cnt + REF_W'(1);
            if (rec_rise && (rec_cnt != {REC_W{1'b1}}))
                rec_cnt <= rec_cnt + REC_W'(1);
        end
    end
endmodule

// File: rtl/freq_lock_detector.sv
`timescale 1ns/1ps
// Frequency lock detector: window comparison against a reference, with
// tolerance select, reference-loss timeout and hold-off before each relock.
module freq_lock_detector
    import fld_pkg::*;
#(
    parameter int WIN_LOG2   = 10,
    parameter int RATIO      = 1,
    parameter int TOL_BASE   = 2,
    parameter int MISS_LIMIT = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_clk_in,
    input  logic       rec_clk_in,
    input  logic [1:0] tol_sel,
    output logic       lock
);
    lock_state_e state_q, state_d;
    logic ref_rise, rec_rise;
    logic ref_expired;
    logic win_done, in_range;
    logic meter_clear;

    fld_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_clk_in), .rise(ref_rise)
    );

    fld_edge_sync #(.STAGES(SYNC_STAGES)) u_rec_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rec_clk_in), .rise(rec_rise)
    );

    fld_ref_watch #(.MISS_LIMIT(MISS_LIMIT)) u_watch (
        .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .expired(ref_expired)
    );

    assign meter_clear = (state_q == ST_NOREF) || ref_expired;

    fld_window_meter #(
        .WIN_LOG2(WIN_LOG2), .RATIO(RATIO), .TOL_BASE(TOL_BASE)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .clear(meter_clear),
        .ref_rise(ref_rise), .rec_rise(rec_rise), .tol_sel(tol_sel),
        .win_done(win_done), .in_range(in_range)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQUIRE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (ref_expired)   state_d = ST_NOREF;
                else if (win_done) state_d = in_range ? ST_LOCKED : ST_HOLDOFF;
            end
            ST_LOCKED: begin
                if (ref_expired)   state_d = ST_NOREF;
                else if (win_done && !in_range) state_d = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                if (ref_expired)   state_d = ST_NOREF;
                else if (win_done) state_d = ST_LOCKED;
            end
            ST_NOREF: begin
                if (ref_rise)      state_d = ST_ACQUIRE;
            end
            default: state_d = ST_ACQUIRE;
        endcase
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            ST_LOCKED:  lock = 1'b1;
            ST_ACQUIRE: lock = 1'b0;
            ST_HOLDOFF: lock = 1'b0;
            ST_NOREF:   lock = 1'b0;
            default:    lock = 1'b0;
        endcase
    end
endmodule

// File: rtl/fld_checker.sv
`timescale 1ns/1ps
module fld_checker #(
    parameter int WIN_LOG2   = 10,
    parameter int MISS_LIMIT = 64
) (
    input logic clk,
    input logic rst_n,
    input logic ref_rise,
    input logic lock
);
    localparam int WIN = 1 << WIN_LOG2;
    localparam int CW  = $clog2(WIN + 2);
    localparam int GW  = $clog2(MISS_LIMIT + 3);
    localparam logic [CW-1:0] SL_MAX = CW'(WIN + 1);
    localparam logic [GW-1:0] G_MAX  = GW'(MISS_LIMIT + 2);

    logic [CW-1:0] since_low;
    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_low <= '0;
            gap       <= '0;
        end else begin
            if (lock)                                   since_low <= '0;
            else if (ref_rise && (since_low != SL_MAX)) since_low <= since_low + CW'(1);
            if (ref_rise)           gap <= '0;
            else if (gap != G_MAX)  gap <= gap + GW'(1);
        end
    end

    p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !lock)
        else $error("lock high during reset");

    p_holdoff_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> (since_low >= CW'(WIN)))
        else $error("lock rose before a full window of reference edges");

    p_missing_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gap >= GW'(MISS_LIMIT + 1)) |-> !lock)
        else $error("lock held with reference missing");

    p_rise_on_ref_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(ref_rise))
        else $error("lock rose without a closing reference edge");
endmodule

bind freq_lock_detector fld_checker #(
    .WIN_LOG2(WIN_LOG2), .MISS_LIMIT(MISS_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .lock(lock)
);

// File: tb/freq_lock_detector_bench.sv
`timescale 1ns/1ps
module freq_lock_detector_bench;
    localparam int WIN_LOG2 = 6;
    localparam int RATIO    = 2;
    localparam int MISS     = 64;
    localparam int WIN      = 1 << WIN_LOG2;
    localparam int EXPN     = WIN * RATIO;
    localparam int S_ACQ = 0, S_LCK = 1, S_HLD = 2, S_NRF = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_drv = 1'b0;
    logic       rec_drv = 1'b0;
    logic [1:0] tol_sel = 2'd1;
    logic       lock;

    int checks = 0, failures = 0;
    bit done = 0;
    bit ref_on = 1, rec_on = 1;
    int dev_off = 0;

    int qr[$], qc[$];
    int m_state = S_ACQ, m_refn = 0, m_recn = 0, m_miss = 0;
    int m_re, m_ce, m_tot, m_dev, m_tol;

    int falls = 0, rises = 0, low_run = 0, min_low = 1000000;
    bit after_fall = 0;
    logic prev_lock = 1'b0;

    freq_lock_detector #(
        .WIN_LOG2(WIN_LOG2), .RATIO(RATIO), .TOL_BASE(2), .MISS_LIMIT(MISS)
    ) u_freq_lock_detector (
        .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_drv), .rec_clk_in(rec_drv),
        .tol_sel(tol_sel), .lock(lock)
    );

    initial forever #2.5 clk = ~clk;

    task automatic check_eq(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic check_true(input string tag, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stimulus generator: reference of period 8, recovered via phase accumulator
    initial begin
        int rc = 0;
        int acc = 0;
        forever begin
            @(negedge clk);
            if (ref_on) begin
                ref_drv = (rc < 4);
                rc = (rc + 1) % 8;
            end else begin
                ref_drv = 1'b0;
                rc = 0;
            end
            if (rec_on) begin
                acc = acc + 2 * (EXPN + dev_off);
                if (acc >= 4 * EXPN) begin
                    acc = acc - 4 * EXPN;
                    rec_drv = ~rec_drv;
                end
            end
        end
    end

    // Behavioural reference model, advanced on every rising clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            qr = '{0, 0, 0, 0};
            qc = '{0, 0, 0, 0};
            m_state = S_ACQ; m_refn = 0; m_recn = 0; m_miss = 0;
        end else begin
            qr.push_back(int'(ref_drv));
            qc.push_back(int'(rec_drv));
            m_re = (qr[2] == 1 && qr[1] == 0) ? 1 : 0;
            m_ce = (qc[2] == 1 && qc[1] == 0) ? 1 : 0;
            void'(qr.pop_front());
            void'(qc.pop_front());
            if (m_state == S_NRF) begin
                if (m_re == 1) begin
                    m_state = S_ACQ; m_refn = 0; m_recn = 0; m_miss = 0;
                end
            end else if (m_re == 0 && m_miss == MISS) begin
                m_state = S_NRF; m_refn = 0; m_recn = 0;
            end else begin
                if (m_re == 1) m_miss = 0;
                else if (m_miss < MISS) m_miss++;
                if (m_re == 1 && m_refn == WIN - 1) begin
                    m_tot = m_recn + m_ce;
                    m_dev = (m_tot >= EXPN) ? m_tot - EXPN : EXPN - m_tot;
                    m_tol = 2 << tol_sel;
                    if (m_state == S_HLD) m_state = S_LCK;
                    else m_state = (m_dev <= m_tol) ? S_LCK : S_HLD;
                    m_refn = 0; m_recn = 0;
                end else begin
                    m_refn += m_re;
                    m_recn += m_ce;
                end
            end
        end
    end

    // Per-cycle comparison and lock activity tracking
    initial begin
        forever begin
            @(negedge clk);
            if (!done) begin
                checks++;
                if (lock !== (rst_n && m_state == S_LCK)) begin
                    failures++;
                    $display("FAIL R5 per-cycle lock actual=%0d expected=%0d",
                             lock, (rst_n && m_state == S_LCK));
                end
                if (prev_lock && !lock) begin falls++; after_fall = 1; low_run = 0; end
                if (!prev_lock && lock) begin
                    rises++;
                    if (after_fall && low_run < min_low) min_low = low_run;
                end
                if (!lock) low_run++;
                prev_lock = lock;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int f0, r0;
        wait_n(4);
        check_eq("R1 lock low during reset", lock, 0);
        rst_n = 1'b1;
        wait_n(400);
        check_eq("R3 no lock before first window closes", lock, 0);
        wait_n(250);
        check_eq("R5 lock after in-range first window", lock, 1);
        tol_sel = 2'd0;
        wait_n(1500);
        check_eq("R4 sel 00 accepts zero offset", lock, 1);

        dev_off = 6; f0 = falls; r0 = rises; min_low = 1000000;
        wait_n(3200);
        check_true("R4 sel 00 rejects offset 6", falls - f0 >= 2, falls - f0, 2);
        check_true("R6 persistent offset toggles lock", rises - r0 >= 2, rises - r0, 2);
        check_true("R6 hold-off lasts one window", min_low >= WIN * 8, min_low, WIN * 8);

        tol_sel = 2'd2;
        wait_n(1200);
        f0 = falls;
        wait_n(1600);
        check_eq("R4 sel 10 accepts offset 6", falls - f0, 0);
        check_eq("R4 sel 10 lock held", lock, 1);

        tol_sel = 2'd3; dev_off = 12;
        wait_n(1200);
        f0 = falls;
        wait_n(1600);
        check_eq("R4 sel 11 accepts offset 12", falls - f0, 0);

        tol_sel = 2'd1; dev_off = -10; f0 = falls;
        wait_n(1300);
        check_true("R4 sel 01 rejects offset -10", falls > f0, falls - f0, 1);

        dev_off = 0;
        wait_n(1600);
        check_eq("R6 relock after offset removed", lock, 1);

        rec_on = 0; f0 = falls;
        wait_n(1300);
        check_true("R2 steady recovered input gives no edges", falls > f0, falls - f0, 1);
        rec_on = 1;
        wait_n(1600);
        check_eq("R2 lock back with recovered edges", lock, 1);

        ref_on = 0;
        wait_n(30);
        check_eq("R7 lock kept before timeout", lock, 1);
        wait_n(70);
        check_eq("R7 lock dropped after reference timeout", lock, 0);
        wait_n(2000);
        check_eq("R7 lock stays low without reference", lock, 0);

        ref_on = 1;
        wait_n(300);
        check_eq("R8 full window needed after reference returns", lock, 0);
        wait_n(400);
        check_eq("R8 lock after reference returns", lock, 1);

        rst_n = 1'b0;
        #1;
        check_eq("R1 asynchronous reset clears lock", lock, 0);
        wait_n(3);
        rst_n = 1'b1;
        wait_n(300);
        check_eq("R1 measurement restarts after reset", lock, 0);
        check_eq("R9 lock low mid-window after reset", lock, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule